// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the register front end of an interrupt router. A bus master reaches the router's configuration through three offsets: a select register holding an 8-bit index, a 32-bit data window that reads or writes whatever register the index names, and a direct end-of-interrupt port. Through the window the master reaches an identification register, a version register, an arbitration register that mirrors the identification value, and a table of 64-bit per-pin routing entries. Each entry is reached as two 32-bit halves at consecutive indices.

Table writes merge the new half with the stored entry. Two status bits per entry (delivery busy and remote-IRR) are owned by the delivery logic and cannot be written through the window. A write that leaves a pin in edge mode forces its remote-IRR flag low. Every accepted table write raises a one-cycle re-service request. An accepted end-of-interrupt write becomes a one-cycle strobe carrying the vector, which goes to the logic that walks the table. The full table is presented in parallel on `route_tbl` for the delivery logic.

Top module: `irq_route_regwin`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the select register, 0x10 is the data window and 0x40 is the end-of-interrupt port. Any other offset reads zero and ignores writes, and the select register changes only on a write to 0x00.
- R2: `rvalid` is high, and `rdata` holds the result, exactly one cycle after `rd_en`. At offset 0x00 a read of any size returns the select index in bits [7:0]. A write of any size stores `wdata[7:0]`.
- R3: A window or end-of-interrupt access whose `acc_bytes` is not 4 is ignored when written and reads zero.
- R4: Indices 0x00 and 0x02 read the 4-bit ID in bits [27:24], with every other bit zero. A write to index 0x00 stores `wdata[27:24]`.
- R5: Index 0x01 reads VERSION in bits [7:0] and (pin count − 1) in bits [23:16]. Writes to indices 0x01 and 0x02 change nothing.
- R6: Entry n is reached at index 0x10+2n (bits [31:0]) and at 0x10+2n+1 (bits [63:32]). Indices 0x03 to 0x0F, and indices past the last entry, read zero.
- R7: In entry bits [31:0], bit 12 reads the live `dstat_in[n]` and bit 14 reads the remote-IRR flag. Neither bit is altered by window writes. `rirr_set[n]` sets the flag and `rirr_clr[n]` clears it, with set winning.
- R8: Bit 15 of an entry is the trigger mode (1 level, 0 edge). A table write that leaves the entry in edge mode clears the remote-IRR flag, and this takes priority over `rirr_set`.
- R9: `service_req` pulses for one cycle in the cycle after each accepted table write, and at no other time.
- R10: When VERSION is 0x20, a 4-byte write to offset 0x40 pulses `eoi_strobe` one cycle later, with `eoi_vector` = `wdata[7:0]`. With VERSION 0x11 the strobe never rises. The port reads zero.
- R11: After reset the select and ID are zero, every entry is 0x0000_0000_0001_0000 (masked, bit 16), remote-IRR flags are clear, and `rvalid`, `service_req` and `eoi_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W | Byte address; only [7:0] decoded |
| acc_bytes | input | 3 | Access size in bytes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid |
| dstat_in | input | NPINS | Per-pin delivery-busy status |
| rirr_set | input | NPINS | Per-pin remote-IRR set pulse |
| rirr_clr | input | NPINS | Per-pin remote-IRR clear pulse |
| route_tbl | output | NPINS*64 | All entries, entry n at [64n+63:64n] |
| service_req | output | 1 | Re-service request pulse |
| eoi_strobe | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Vector carried with the strobe |

## Verification
Every result of this block is due one cycle after its stimulus. Read data and `rvalid` follow the posedge that samples `rd_en`. Stored state, `service_req` and `eoi_strobe` follow the posedge that samples `wr_en`. The bench drives on falling edges. Each read pushes its expected word into a queue, and a monitor pops and compares it on the falling edge at which `rvalid` is high. Pulse outputs are checked on the falling edge that ends the write, which is one posedge after the write was sampled. Because status inputs feed the read path live, they are changed before the read that depends on them is issued.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL0 = 8'h10;

  localparam int ID_LSB    = 24;
  localparam int ID_W      = 4;
  localparam int MAXE_LSB  = 16;
  localparam int DSTAT_BIT = 12;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;

  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;
  localparam logic [63:0] ENT_RW    = ~((64'd1 << DSTAT_BIT) | (64'd1 << RIRR_BIT));

  typedef struct packed {
    logic sel_wr;
    logic sel_rd;
    logic win_wr;
    logic win_rd;
    logic eoi_wr;
  } acc_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import irq_regwin_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] ofs,
  input  logic [2:0] acc_bytes,
  output acc_t       acc
);
  logic word;
  assign word = (acc_bytes == 3'd4);

  always_comb begin
    acc        = '0;
    acc.sel_wr = wr_en && (ofs == OFS_SEL);
    acc.sel_rd = rd_en && (ofs == OFS_SEL);
    acc.win_wr = wr_en && word && (ofs == OFS_WIN);
    acc.win_rd = rd_en && word && (ofs == OFS_WIN);
    acc.eoi_wr = wr_en && word && (ofs == OFS_EOI);
  end
endmodule

// File: rtl/regwin_entry.sv
module regwin_entry
  import irq_regwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  output logic [63:0] ent_q
);
  logic [63:0] cfg_q, cfg_d;
  logic        rirr_q, rirr_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_lo) cfg_d[31:0]  = wdata;
    if (wr_hi) cfg_d[63:32] = wdata;
    cfg_d = cfg_d & ENT_RW;

    rirr_d = rirr_q;
    if (rirr_clr) rirr_d = 1'b0;
    if (rirr_set) rirr_d = 1'b1;
    if ((wr_lo || wr_hi) && !cfg_d[TRIG_BIT]) rirr_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= ENT_RESET;
      rirr_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      rirr_q <= rirr_d;
    end
  end

  always_comb begin
    ent_q           = cfg_q;
    ent_q[RIRR_BIT] = rirr_q;
  end
endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import irq_regwin_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h20
)(
  input  logic [7:0]              sel,
  input  logic [ID_W-1:0]         id,
  input  logic [NPINS-1:0][63:0]  ents,
  input  logic [NPINS-1:0]        dstat,
  output logic [31:0]             word
);
  localparam logic [7:0] MAXE = 8'(NPINS - 1);

  logic [7:0] off;
  logic       in_tbl;
  assign off    = sel - IDX_TBL0;
  assign in_tbl = (sel >= IDX_TBL0);

  always_comb begin
    word = '0;
    if (sel == IDX_ID || sel == IDX_ARB) begin
      word[ID_LSB +: ID_W] = id;
    end else if (sel == IDX_VER) begin
      word[7:0]           = VERSION;
      word[MAXE_LSB +: 8] = MAXE;
    end else if (in_tbl) begin
      for (int i = 0; i < NPINS; i++) begin
        if (off[7:1] == 7'(i)) begin
          if (off[0]) begin
            word = ents[i][63:32];
          end else begin
            word            = ents[i][31:0];
            word[DSTAT_BIT] = dstat[i];
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import irq_regwin_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] VERSION = 8'h20
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2:0]            acc_bytes,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  rvalid,
  input  logic [NPINS-1:0]      dstat_in,
  input  logic [NPINS-1:0]      rirr_set,
  input  logic [NPINS-1:0]      rirr_clr,
  output logic [NPINS*64-1:0]   route_tbl,
  output logic                  service_req,
  output logic                  eoi_strobe,
  output logic [7:0]            eoi_vector
);
  localparam logic EOI_OK = (VERSION == 8'h20);

  acc_t                    acc;
  logic [7:0]              sel_q;
  logic [ID_W-1:0]         id_q;
  logic [NPINS-1:0][63:0]  ents;
  logic [31:0]             win_word;
  logic [7:0]              t_off;
  logic                    t_hit;

  regwin_decode u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .ofs(addr[7:0]),
    .acc_bytes(acc_bytes), .acc(acc)
  );

  assign t_off = sel_q - IDX_TBL0;
  assign t_hit = (sel_q >= IDX_TBL0) && (t_off[7:1] < 7'(NPINS));

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic hit_g;
    assign hit_g = acc.win_wr && t_hit && (t_off[7:1] == 7'(g));
    regwin_entry u_ent (
      .clk(clk), .rst(rst),
      .wr_lo(hit_g && !t_off[0]), .wr_hi(hit_g && t_off[0]),
      .wdata(wdata), .rirr_set(rirr_set[g]), .rirr_clr(rirr_clr[g]),
      .ent_q(ents[g])
    );
    assign route_tbl[g*64 +: 64] = ents[g];
  end

  regwin_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_mux (
    .sel(sel_q), .id(id_q), .ents(ents), .dstat(dstat_in), .word(win_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      id_q        <= '0;
      rdata       <= '0;
      rvalid      <= 1'b0;
      service_req <= 1'b0;
      eoi_strobe  <= 1'b0;
      eoi_vector  <= '0;
    end else begin
      if (acc.sel_wr) sel_q <= wdata[7:0];
      if (acc.win_wr && sel_q == IDX_ID) id_q <= wdata[ID_LSB +: ID_W];

      rvalid <= rd_en;
      if (acc.sel_rd)      rdata <= {24'd0, sel_q};
      else if (acc.win_rd) rdata <= win_word;
      else                 rdata <= '0;

      service_req <= acc.win_wr && t_hit;
      eoi_strobe  <= acc.eoi_wr && EOI_OK;
      if (acc.eoi_wr && EOI_OK) eoi_vector <= wdata[7:0];
    end
  end
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20
)(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] ofs,
  input logic [2:0] acc_bytes,
  input logic [7:0] sel_q,
  input logic       rvalid,
  input logic       service_req,
  input logic       eoi_strobe
);
  localparam logic [7:0] TOP_IDX = 8'(16 + 2 * NPINS);

  // R2
  rvalid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst)) |-> rvalid);

  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> !rvalid);

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && ofs == 8'h00) |-> $stable(sel_q));

  // R9
  svc_src_chk: assert property (@(posedge clk) disable iff (rst)
    service_req |-> $past(wr_en && ofs == 8'h10 && acc_bytes == 3'd4
                          && sel_q >= 8'h10 && sel_q < TOP_IDX));

  // R10
  eoi_src_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_strobe |-> ($past(wr_en && ofs == 8'h40 && acc_bytes == 3'd4)
                    && VERSION == 8'h20));
endmodule

bind irq_route_regwin regwin_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ofs(addr[7:0]),
  .acc_bytes(acc_bytes), .sel_q(sel_q), .rvalid(rvalid),
  .service_req(service_req), .eoi_strobe(eoi_strobe)
);

// File: tb/irq_route_regwin_bench.sv
module irq_route_regwin_bench;
  localparam int NPINS = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]       addr = '0;
  logic [2:0]        acc_bytes = 3'd4;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [NPINS-1:0]  dstat_in = '0, rirr_set = '0, rirr_clr = '0;
  logic [NPINS*64-1:0] route_tbl, route_tbl_o;
  logic              service_req, eoi_strobe, service_req_o, eoi_strobe_o;
  logic [7:0]        eoi_vector, eoi_vector_o;
  logic [31:0]       rdata_o;
  logic              rvalid_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_route_regwin #(.NPINS(NPINS), .VERSION(8'h20)) u_irq_route_regwin (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_bytes(acc_bytes), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .dstat_in(dstat_in), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .route_tbl(route_tbl), .service_req(service_req),
    .eoi_strobe(eoi_strobe), .eoi_vector(eoi_vector));

  irq_route_regwin #(.NPINS(NPINS), .VERSION(8'h11)) u_irq_route_regwin_v11 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_bytes(acc_bytes), .wdata(wdata), .rdata(rdata_o), .rvalid(rvalid_o),
    .dstat_in(dstat_in), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .route_tbl(route_tbl_o), .service_req(service_req_o),
    .eoi_strobe(eoi_strobe_o), .eoi_vector(eoi_vector_o));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when rvalid is seen
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected rvalid expected none");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata, e, t);
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [2:0] b, input logic [31:0] d);
    wr_en = 1'b1; addr = a; acc_bytes = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; acc_bytes = 3'd4;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [2:0] b,
                        input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a; acc_bytes = b;
    @(negedge clk);
    rd_en = 1'b0; acc_bytes = 3'd4;
  endtask

  task automatic sel(input logic [7:0] i);
    bus_wr(12'h000, 3'd4, {24'd0, i});
  endtask

  task automatic pulse_set(input int n);
    rirr_set[n] = 1'b1; @(negedge clk); rirr_set[n] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check({29'd0, rvalid, service_req, eoi_strobe}, 32'd0, "R11 outputs idle");
    check(route_tbl[3*64 +: 32], 32'h0001_0000, "R11 entry reset (port)");
    bus_rd(12'h000, 3'd4, 32'h0, "R11 select reset");
    bus_rd(12'h010, 3'd4, 32'h0, "R11 id reset");
    sel(8'h16);
    bus_rd(12'h010, 3'd4, 32'h0001_0000, "R11 entry3 lo reset");
    // R2 select readback with narrow size
    bus_rd(12'h000, 3'd1, 32'h0000_0016, "R2 select readback");
    // R1 high address bits ignored, R4 id write
    bus_wr(12'hF00, 3'd2, 32'h0000_0000);
    bus_wr(12'hA10, 3'd4, 32'hFA55_AA55);
    check({31'd0, service_req}, 32'd0, "R9 no service on id write");
    bus_rd(12'h010, 3'd4, 32'h0A00_0000, "R4 id read");
    sel(8'h02);
    bus_rd(12'h010, 3'd4, 32'h0A00_0000, "R4 arb mirrors id");
    bus_wr(12'h010, 3'd4, 32'h0F00_0000);
    bus_rd(12'h010, 3'd4, 32'h0A00_0000, "R5 arb write ignored");
    // R5 version
    sel(8'h01);
    bus_rd(12'h010, 3'd4, 32'h0017_0020, "R5 version read");
    bus_wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    bus_rd(12'h010, 3'd4, 32'h0017_0020, "R5 version write ignored");
    // R3 narrow window access
    sel(8'h00);
    bus_wr(12'h010, 3'd2, 32'h0300_0000);
    check({31'd0, service_req}, 32'd0, "R3 narrow write no effect");
    bus_rd(12'h010, 3'd2, 32'h0, "R3 narrow read zero");
    bus_rd(12'h010, 3'd4, 32'h0A00_0000, "R3 id untouched");
    // R1 unknown offset, R10 eoi read
    bus_rd(12'h020, 3'd4, 32'h0, "R1 unknown offset");
    bus_rd(12'h040, 3'd4, 32'h0, "R10 eoi reads zero");
    // R6 / R7 entry 3
    sel(8'h16);
    bus_wr(12'h010, 3'd4, 32'h0001_D0A5);
    check({31'd0, service_req}, 32'd1, "R9 service after table write");
    bus_rd(12'h010, 3'd4, 32'h0001_80A5, "R7 ro bits not written");
    pulse_set(3);
    bus_rd(12'h010, 3'd4, 32'h0001_C0A5, "R7 rirr set");
    dstat_in[3] = 1'b1;
    bus_rd(12'h010, 3'd4, 32'h0001_D0A5, "R7 dstat live");
    bus_wr(12'h010, 3'd4, 32'h0000_80A6);
    bus_rd(12'h010, 3'd4, 32'h0000_D0A6, "R7 rirr kept on level write");
    dstat_in[3] = 1'b0;
    bus_wr(12'h010, 3'd4, 32'h0000_00A6);
    bus_rd(12'h010, 3'd4, 32'h0000_00A6, "R8 edge clears rirr");
    sel(8'h17);
    bus_wr(12'h010, 3'd4, 32'hAB00_0000);
    bus_rd(12'h010, 3'd4, 32'hAB00_0000, "R6 entry3 hi");
    check(route_tbl[3*64 +: 32], 32'h0000_00A6, "R6 lo kept after hi write");
    sel(8'h16);
    bus_wr(12'h010, 3'd4, 32'h0000_80A6);
    pulse_set(3);
    sel(8'h17);
    bus_wr(12'h010, 3'd4, 32'h1100_0000);
    sel(8'h16);
    bus_rd(12'h010, 3'd4, 32'h0000_C0A6, "R7 hi write keeps rirr");
    rirr_clr[3] = 1'b1; @(negedge clk); rirr_clr[3] = 1'b0;
    bus_rd(12'h010, 3'd4, 32'h0000_80A6, "R7 rirr clear");
    // R6 boundaries
    sel(8'h3E);
    bus_rd(12'h010, 3'd4, 32'h0001_0000, "R6 last entry lo");
    sel(8'h40);
    bus_wr(12'h010, 3'd4, 32'h1234_5678);
    check({31'd0, service_req}, 32'd0, "R9 no service past table");
    bus_rd(12'h010, 3'd4, 32'h0, "R6 past table zero");
    sel(8'h05);
    bus_rd(12'h010, 3'd4, 32'h0, "R6 gap index zero");
    // R10 eoi
    bus_wr(12'h040, 3'd4, 32'h0000_015A);
    check({23'd0, eoi_strobe, eoi_vector}, {23'd0, 1'b1, 8'h5A}, "R10 eoi strobe");
    check({31'd0, eoi_strobe_o}, 32'd0, "R10 old version no strobe");
    @(negedge clk);
    check({31'd0, eoi_strobe}, 32'd0, "R10 strobe one cycle");
    bus_wr(12'h040, 3'd2, 32'h0000_0033);
    check({31'd0, eoi_strobe}, 32'd0, "R3 narrow eoi ignored");
    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule